// File: doc/BRIEF.md
# Multi-Width Negate Execution Slice

This block is one execution slice of an integer datapath. It is handed a single-operand instruction as an opcode byte and a ModRM byte, along with three prefix indicators and the current 64-bit contents of the destination register. It decodes whether the instruction is a negate and at what width. It then forms zero minus the operand at that width and a full set of six arithmetic status flags. Finally it merges the narrow result back into the 64-bit register image for write-back.

The result is registered: one cycle after an input strobe, `res_valid_o` pulses and the write-back value, flags, fault and miss outputs are valid. The slice handles register destinations only. A lock prefix on a register target raises an undefined-opcode fault. An instruction that is not a negate is reported on a separate miss output. In both of those cases the register image passes through unchanged and the flag outputs keep their previous values.

Top module: `neg_exec_unit`

## Requirements
- R1: `res_valid_o` is high in exactly the cycle after a cycle with `valid_i` high. All other outputs update only on such a result cycle.
- R2: Opcode 0xF6 with ModRM reg field (bits 5:3) equal to 3 negates the low 8 bits. Bits 63:8 of the write-back value equal those of `reg_i`. The prefixes do not change the width.
- R3: Opcode 0xF7 with reg field 3, with `wide_i` and `osz_i` both low, negates the low 32 bits. The result is zero-extended, so write-back bits 63:32 are 0.
- R4: Opcode 0xF7 with reg field 3 and `wide_i` high negates all 64 bits. `wide_i` takes priority over `osz_i`.
- R5: Opcode 0xF7 with reg field 3, `osz_i` high and `wide_i` low negates the low 16 bits. Bits 63:16 of `reg_i` are kept.
- R6: `cf_o` is 0 when the operand at the selected width is zero and 1 otherwise.
- R7: `of_o` is 1 only when the operand is the most negative value of the width. `sf_o` is the top bit of the result at the width. `zf_o` is 1 when the result at the width is all zeros.
- R8: `af_o` is 1 when operand bits 3:0 are nonzero. `pf_o` is 1 when result bits 7:0 hold an even number of ones.
- R9: When a negate is decoded with `lock_i` high and ModRM mod field (bits 7:6) equal to 3, `ud_o` is raised. The write-back value equals `reg_i` and all six flags keep their previous values.
- R10: Any opcode other than 0xF6/0xF7, or a reg field other than 3, raises `nx_o`. The write-back value equals `reg_i` and the flags keep their previous values. `ud_o` and `nx_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 8 | Opcode byte |
| modrm_i | input | 8 | ModRM byte (mod 7:6, reg 5:3, r/m 2:0) |
| lock_i | input | 1 | Lock prefix present |
| osz_i | input | 1 | Operand-size override present |
| wide_i | input | 1 | 64-bit width prefix bit |
| reg_i | input | 64 | Current destination register value |
| wb_value_o | output | 64 | Merged write-back value |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| af_o | output | 1 | Auxiliary-carry flag |
| pf_o | output | 1 | Parity flag |
| ud_o | output | 1 | Undefined-opcode fault |
| nx_o | output | 1 | Not a negate instruction |
| res_valid_o | output | 1 | Result valid, one cycle after `valid_i` |

## Verification
The assertions assume the following about the inputs:
- `reg_i` and the prefix inputs are stable and meaningful only in cycles with `valid_i` high.
- The mod field decides between register and memory targets only for the lock check.

The stimulus drives every input on the falling edge. It follows each strobe with a mix of strobes and idle cycles, so that the hold-on-miss and hold-on-fault rules can be observed against earlier flag values. It mixes directed boundary operands with random opcodes, ModRM bytes and prefix combinations. Some of the random opcodes and ModRM bytes are deliberately non-matching.

// File: rtl/neg_pkg.sv
package neg_pkg;
   typedef enum logic [1:0] {
      OPW_8  = 2'd0,
      OPW_16 = 2'd1,
      OPW_32 = 2'd2,
      OPW_64 = 2'd3
   } opw_e;

   typedef struct packed {
      logic cf;
      logic of;
      logic sf;
      logic zf;
      logic af;
      logic pf;
   } aflags_t;
endpackage

// File: rtl/neg_decode.sv
module neg_decode
   import neg_pkg::*;
#(
   parameter logic [7:0] OPC_NARROW = 8'hF6,
   parameter logic [7:0] OPC_WIDE   = 8'hF7,
   parameter logic [2:0] EXT_FIELD  = 3'd3
) (
   input  logic [7:0] opcode_i,
   input  logic [7:0] modrm_i,
   input  logic       lock_i,
   input  logic       osz_i,
   input  logic       wide_i,
   output logic       hit_o,
   output logic       ud_o,
   output opw_e       opw_o
);
   localparam logic [1:0] MOD_REG = 2'b11;

   logic opc_narrow, opc_wide;

   assign opc_narrow = (opcode_i == OPC_NARROW);
   assign opc_wide   = (opcode_i == OPC_WIDE);
   assign hit_o      = (opc_narrow || opc_wide) && (modrm_i[5:3] == EXT_FIELD);
   assign ud_o       = hit_o && lock_i && (modrm_i[7:6] == MOD_REG);

   always_comb begin
      if (opc_narrow)  opw_o = OPW_8;
      else if (wide_i) opw_o = OPW_64;
      else if (osz_i)  opw_o = OPW_16;
      else             opw_o = OPW_32;
   end
endmodule

// File: rtl/neg_core.sv
module neg_core
   import neg_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] operand_i,
   input  opw_e              opw_i,
   output logic [DATA_W-1:0] result_o,
   output aflags_t           flags_o
);
   localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;

   if (DATA_W != 64) begin : g_bad_width
      $error("neg_core: DATA_W must be 64 to match the four width codes");
   end

   logic [DATA_W-1:0] lane_res [NUM_LANES];
   aflags_t           lane_flg [NUM_LANES];

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam int LW = 8 << g;
      logic [LW-1:0] src, neg;
      assign src         = operand_i[LW-1:0];
      assign neg         = '0 - src;
      assign lane_res[g] = DATA_W'(neg);
      assign lane_flg[g] = '{cf: |src,
                             of: (src == {1'b1, {(LW-1){1'b0}}}),
                             sf: neg[LW-1],
                             zf: ~|neg,
                             af: |src[3:0],
                             pf: ~^neg[7:0]};
   end

   assign result_o = lane_res[opw_i];
   assign flags_o  = lane_flg[opw_i];

   always_comb begin
      a_r6_carry_vs_zero: assert (flags_o.cf == ~flags_o.zf);
      a_r7_of_implies_sf: assert (!flags_o.of || flags_o.sf);
   end
endmodule

// File: rtl/neg_merge.sv
module neg_merge
   import neg_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] reg_i,
   input  logic [DATA_W-1:0] res_i,
   input  opw_e              opw_i,
   output logic [DATA_W-1:0] wb_o
);
   localparam int W8  = 8;
   localparam int W16 = 16;
   localparam int W32 = 32;

   always_comb begin
      unique case (opw_i)
         OPW_8:   wb_o = {reg_i[DATA_W-1:W8],  res_i[W8-1:0]};
         OPW_16:  wb_o = {reg_i[DATA_W-1:W16], res_i[W16-1:0]};
         OPW_32:  wb_o = DATA_W'(res_i[W32-1:0]);
         default: wb_o = res_i;
      endcase
   end
endmodule

// File: rtl/neg_exec_unit.sv
module neg_exec_unit
   import neg_pkg::*;
#(
   parameter int          DATA_W     = 64,
   parameter logic [7:0]  OPC_NARROW = 8'hF6,
   parameter logic [7:0]  OPC_WIDE   = 8'hF7,
   parameter logic [2:0]  EXT_FIELD  = 3'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [7:0]        opcode_i,
   input  logic [7:0]        modrm_i,
   input  logic              lock_i,
   input  logic              osz_i,
   input  logic              wide_i,
   input  logic [DATA_W-1:0] reg_i,
   output logic [DATA_W-1:0] wb_value_o,
   output logic              cf_o,
   output logic              of_o,
   output logic              sf_o,
   output logic              zf_o,
   output logic              af_o,
   output logic              pf_o,
   output logic              ud_o,
   output logic              nx_o,
   output logic              res_valid_o
);
   logic              hit, ud;
   opw_e              opw;
   logic [DATA_W-1:0] neg_res, merged;
   aflags_t           flg_d, flg_q;
   logic [DATA_W-1:0] wb_q;
   logic              ud_q, nx_q, vld_q;

   neg_decode #(.OPC_NARROW(OPC_NARROW), .OPC_WIDE(OPC_WIDE), .EXT_FIELD(EXT_FIELD)) u_dec (
      .opcode_i(opcode_i), .modrm_i(modrm_i), .lock_i(lock_i), .osz_i(osz_i),
      .wide_i(wide_i), .hit_o(hit), .ud_o(ud), .opw_o(opw)
   );

   neg_core #(.DATA_W(DATA_W)) u_core (
      .operand_i(reg_i), .opw_i(opw), .result_o(neg_res), .flags_o(flg_d)
   );

   neg_merge #(.DATA_W(DATA_W)) u_mrg (
      .reg_i(reg_i), .res_i(neg_res), .opw_i(opw), .wb_o(merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         ud_q  <= 1'b0;
         nx_q  <= 1'b0;
         wb_q  <= '0;
         flg_q <= '0;
      end else begin
         vld_q <= valid_i;
         ud_q  <= valid_i && ud;
         nx_q  <= valid_i && !hit;
         if (valid_i) begin
            if (hit && !ud) begin
               wb_q  <= merged;
               flg_q <= flg_d;
            end else begin
               wb_q  <= reg_i;
            end
         end
      end
   end

   assign wb_value_o  = wb_q;
   assign {cf_o, of_o, sf_o, zf_o, af_o, pf_o} = flg_q;
   assign ud_o        = ud_q;
   assign nx_o        = nx_q;
   assign res_valid_o = vld_q;

   a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> res_valid_o);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !res_valid_o);
   a_r9_fault_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && ud_o) |-> (wb_value_o == $past(reg_i)));
   a_r9_fault_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && ud_o) |-> $stable({cf_o, of_o, sf_o, zf_o, af_o, pf_o}));
   a_r10_miss_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && nx_o) |-> $stable({cf_o, of_o, sf_o, zf_o, af_o, pf_o}));
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ud_o && nx_o));
   a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !ud_o && !nx_o &&
       $past(opcode_i == OPC_WIDE && !wide_i && !osz_i)) |-> (wb_value_o[DATA_W-1:32] == '0));
endmodule

// File: tb/sim_neg_exec_unit.sv
module sim_neg_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [7:0]  opcode_i = '0;
   logic [7:0]  modrm_i = '0;
   logic        lock_i = 1'b0, osz_i = 1'b0, wide_i = 1'b0;
   logic [63:0] reg_i = '0;
   logic [63:0] wb_value_o;
   logic        cf_o, of_o, sf_o, zf_o, af_o, pf_o, ud_o, nx_o, res_valid_o;

   always #5 clk = ~clk;

   neg_exec_unit u0 (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i), .modrm_i(modrm_i),
      .lock_i(lock_i), .osz_i(osz_i), .wide_i(wide_i), .reg_i(reg_i),
      .wb_value_o(wb_value_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o),
      .af_o(af_o), .pf_o(pf_o), .ud_o(ud_o), .nx_o(nx_o), .res_valid_o(res_valid_o)
   );

   int tests = 0;
   int fails = 0;

   // reference state
   bit          e_valid = 0, e_ud = 0, e_nx = 0;
   logic [63:0] e_wb = '0;
   bit [5:0]    e_flg = '0;  // {cf,of,sf,zf,af,pf}
   string       e_tag = "R1";

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic compare();
      chk("R1 valid", 64'(res_valid_o), 64'(e_valid));
      chk({e_tag, " wb"}, wb_value_o, e_wb);
      chk("R6 cf", 64'(cf_o), 64'(e_flg[5]));
      chk("R7 of", 64'(of_o), 64'(e_flg[4]));
      chk("R7 sf", 64'(sf_o), 64'(e_flg[3]));
      chk("R7 zf", 64'(zf_o), 64'(e_flg[2]));
      chk("R8 af", 64'(af_o), 64'(e_flg[1]));
      chk("R8 pf", 64'(pf_o), 64'(e_flg[0]));
      chk("R9 ud", 64'(ud_o), 64'(e_ud));
      chk("R10 nx", 64'(nx_o), 64'(e_nx));
   endtask

   task automatic model(input bit v, input logic [7:0] opc, input logic [7:0] mrm,
                        input bit lk, input bit os, input bit wd, input logic [63:0] rv);
      bit hit;
      int w;
      logic [63:0] mask, opm, res;
      e_valid = v;
      if (!v) begin
         e_ud = 0;
         e_nx = 0;
         return;
      end
      hit  = (opc == 8'hF6 || opc == 8'hF7) && (mrm[5:3] == 3'd3);
      e_nx = !hit;
      e_ud = hit && lk && (mrm[7:6] == 2'b11);
      if (!hit || e_ud) begin
         e_wb  = rv;
         e_tag = hit ? "R9" : "R10";
         return;
      end
      w = (opc == 8'hF6) ? 8 : wd ? 64 : os ? 16 : 32;
      e_tag = (w == 8) ? "R2" : (w == 16) ? "R5" : (w == 32) ? "R3" : "R4";
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      opm  = rv & mask;
      res  = (64'd0 - opm) & mask;
      e_wb = (w < 32) ? ((rv & ~mask) | res) : res;
      e_flg[5] = (opm != 0);
      e_flg[4] = (opm == (64'd1 << (w - 1)));
      e_flg[3] = res[w-1];
      e_flg[2] = (res == 0);
      e_flg[1] = (rv[3:0] != 0);
      e_flg[0] = ~^res[7:0];
   endtask

   task automatic step(input bit v, input logic [7:0] opc, input logic [7:0] mrm,
                       input bit lk, input bit os, input bit wd, input logic [63:0] rv);
      @(negedge clk);
      compare();
      valid_i = v; opcode_i = opc; modrm_i = mrm;
      lock_i = lk; osz_i = os; wide_i = wd; reg_i = rv;
      model(v, opc, mrm, lk, os, wd, rv);
   endtask

   initial begin
      #3000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare();                 // reset state: all zero (R1)
      rst_n = 1'b1;
      // R2: 8-bit forms, upper bits kept, min value overflows
      step(1, 8'hF6, 8'hD8, 0, 0, 0, 64'h1122334455667780);
      step(1, 8'hF6, 8'hD8, 0, 1, 1, 64'hAAAAAAAAAAAAAA00);
      step(0, 8'h00, 8'h00, 0, 0, 0, 64'h0);
      // R3: 32-bit, zero extended
      step(1, 8'hF7, 8'hD8, 0, 0, 0, 64'hFFFFFFFF80000000);
      step(1, 8'hF7, 8'hDB, 0, 0, 0, 64'h0000000000000001);
      // R4: 64-bit, priority over override
      step(1, 8'hF7, 8'hD8, 0, 0, 1, 64'h8000000000000000);
      step(1, 8'hF7, 8'hD8, 0, 1, 1, 64'h0000000000000010);
      // R5: 16-bit
      step(1, 8'hF7, 8'hD8, 0, 1, 0, 64'hDEADBEEF12348000);
      step(1, 8'hF7, 8'hD8, 0, 1, 0, 64'h0123456789AB0000);
      // R9: lock on register target faults; lock with memory mod does not
      step(1, 8'hF7, 8'hD8, 1, 0, 1, 64'h5555555555555555);
      step(1, 8'hF7, 8'h18, 1, 0, 1, 64'h5555555555555555);
      // R10: wrong opcode / wrong reg field
      step(1, 8'hF8, 8'hD8, 0, 0, 0, 64'h0000000000000007);
      step(1, 8'hF7, 8'hD0, 0, 0, 0, 64'h0000000000000007);
      step(0, 8'h00, 8'h00, 0, 0, 0, 64'h0);
      for (int i = 0; i < 400; i++) begin
         logic [7:0] opc, mrm;
         logic [63:0] rv;
         opc = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (($urandom_range(0, 1) != 0) ? 8'hF7 : 8'hF6);
         mrm = 8'($urandom);
         if ($urandom_range(0, 2) != 0) mrm[5:3] = 3'd3;
         rv = {32'($urandom), 32'($urandom)};
         case ($urandom_range(0, 3))
            0: rv[31:0] = 32'h0;
            1: rv[15:0] = 16'h8000;
            default: ;
         endcase
         step(1'($urandom_range(0, 3) != 0), opc, mrm, 1'($urandom_range(0, 3) == 0),
              1'($urandom), 1'($urandom), rv);
      end
      step(0, 8'h00, 8'h00, 0, 0, 0, 64'h0);
      step(0, 8'h00, 8'h00, 0, 0, 0, 64'h0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule